// File: doc/BRIEF.md
# Parallel Four-Bank Byte Substitution Unit

This block is a single-cycle byte-substitution execution unit for a 32-bit processor pipeline. It holds four independent lookup banks of 256 entries by 8 bits (1 KB in total), each with its own address input. A lookup operation takes a 32-bit source word and an 8-bit control field. Each source byte addresses one bank, so up to four substitutions run in parallel. The substituted or untouched bytes then pass through a byte-lane select stage and a two-stage logarithmic byte rotator, and the 32-bit result is registered.

A load operation writes one byte into each bank at a shared 8-bit address in a single cycle. The unit returns the load data unchanged as its result. The banks can be rewritten at run time, so the unit can serve different ciphers. A cipher with 6-bit-in/4-bit-out tables can keep two 64-entry tables in each bank, with the upper address bits choosing the table.

A chaining bit in the control field takes the previous result instead of the source port as the source word. This feedback lets successive operations build arbitrary byte substitutions and permutations.

Top module: `sbox_unit`

## Requirements
- R1: While reset is asserted and after its release, `res_valid` is 0 and `res_data` is 0 until the first accepted operation.
- R2: When `wr_valid` is 1, byte i of `wr_data` (bits 8i+7..8i) is written into bank i at address `wr_addr`. A lookup in any later cycle sees the new entry.
- R3: A load operation produces `res_valid` = 1 and `res_data` equal to `wr_data` in the following cycle.
- R4: In a lookup, when control bit i (bits 3..0 are the lane enables) is 1, byte i of the pre-rotation word is the entry of bank i addressed by source byte i.
- R5: In a lookup, when lane enable bit i is 0, byte i of the pre-rotation word is source byte i, unchanged.
- R6: When control bit 6 (inverse select) is 1, an enabled lane i reads bank (i+2) mod 4 instead of bank i, still addressed by source byte i.
- R7: Control bits 5..4 give a rotate amount k from 0 to 3. The pre-rotation word is rotated left by 8k bits, so byte i moves to byte (i+k) mod 4.
- R8: A control value of 0x0F substitutes all four bytes through their own banks with no rotation, which is a full word substitution.
- R9: When control bit 7 (chain) is 1, the source word used for addressing and for pass-through is the current `res_data` value instead of `rd_src`.
- R10: When `rd_valid` and `wr_valid` are both 1 in one cycle, the load is performed, the result is `wr_data`, and the lookup is dropped.
- R11: `res_valid` is 1 in exactly the cycle after an accepted operation and 0 after a cycle with no operation. `res_data` holds its value when no operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_valid | input | 1 | Lookup operation request |
| rd_src | input | 32 | Lookup source word |
| rd_ctrl | input | 8 | Lookup control: [3:0] lane enables, [5:4] rotate, [6] inverse, [7] chain |
| wr_valid | input | 1 | Load operation request |
| wr_data | input | 32 | Load data, byte i goes to bank i |
| wr_addr | input | 8 | Shared bank address for the load |
| res_valid | output | 1 | Result valid, one cycle after an accepted operation |
| res_data | output | 32 | Registered result word |

## Verification
Every result appears one clock edge after its operation is presented, because the banks are read combinationally and only the result register lies between the inputs and `res_data`. A bank write made at an edge is visible to a lookup presented in the next cycle. The bench drives inputs on the falling edge and samples `res_valid` and `res_data` one nanosecond after the following rising edge. It then compares them against a software image of the four banks that it updates itself on every load. Idle cycles placed after operations check that `res_valid` drops, and the chained lookup uses the expected value of the previous result.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef struct packed {
        logic       chain;
        logic       inv;
        logic [1:0] rot;
        logic [3:0] en;
    } sbox_ctrl_t;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } sbox_res_t;
endpackage

// File: rtl/sbox_bank.sv
module sbox_bank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

    // R2
    bank_wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !$isunknown(waddr)) |=> ((raddr != $past(waddr)) || (rdata == $past(wdata))));
endmodule

// File: rtl/sbox_lane_sel.sv
module sbox_lane_sel #(
    parameter int DW = 8
) (
    input  logic          en,
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] sub,
    output logic [DW-1:0] sel
);
    always_comb begin
        sel = en ? sub : raw;
    end
endmodule

// File: rtl/sbox_rotator.sv
module sbox_rotator #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic [LANES*BYTE_W-1:0]   din,
    input  logic [$clog2(LANES)-1:0]  amt,
    output logic [LANES*BYTE_W-1:0]   dout
);
    localparam int W   = LANES * BYTE_W;
    localparam int NST = $clog2(LANES);

    logic [W-1:0] stg [NST+1];

    assign stg[0] = din;

    for (genvar s = 0; s < NST; s++) begin : g_stage
        localparam int SH = (1 << s) * BYTE_W;
        always_comb begin
            stg[s+1] = amt[s] ? {stg[s][W-SH-1:0], stg[s][W-1:W-SH]} : stg[s];
        end
    end

    assign dout = stg[NST];

    // R7
    always_comb begin
        rot_ones_chk: assert ($countones(dout) == $countones(din));
    end
endmodule

// File: rtl/sbox_unit.sv
module sbox_unit
    import sbox_pkg::*;
#(
    parameter int LN = LANES,
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_valid,
    input  logic [LN*BW-1:0]   rd_src,
    input  logic [7:0]         rd_ctrl,
    input  logic               wr_valid,
    input  logic [LN*BW-1:0]   wr_data,
    input  logic [AW-1:0]      wr_addr,
    output logic               res_valid,
    output logic [LN*BW-1:0]   res_data
);
    localparam int W    = LN * BW;
    localparam int HALF = LN / 2;

    sbox_ctrl_t ctl;
    sbox_res_t  st_d, st_q;
    logic [W-1:0] src_w, sub_w, sel_w, rot_w;
    logic [BW-1:0] bank_out [LN];

    assign ctl   = sbox_ctrl_t'(rd_ctrl);
    assign src_w = ctl.chain ? st_q.data : rd_src;

    for (genvar j = 0; j < LN; j++) begin : g_bank
        localparam int PARTNER = (j + HALF) % LN;
        logic [AW-1:0] addr_j;
        assign addr_j = ctl.inv ? AW'(src_w[PARTNER*BW +: BW]) : AW'(src_w[j*BW +: BW]);
        sbox_bank #(.AW(AW), .DW(BW)) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_valid),
            .waddr (wr_addr),
            .wdata (wr_data[j*BW +: BW]),
            .raddr (addr_j),
            .rdata (bank_out[j])
        );
    end

    for (genvar i = 0; i < LN; i++) begin : g_lane
        localparam int ALT = (i + HALF) % LN;
        assign sub_w[i*BW +: BW] = ctl.inv ? bank_out[ALT] : bank_out[i];
        sbox_lane_sel #(.DW(BW)) sel_i (
            .en  (ctl.en[i]),
            .raw (src_w[i*BW +: BW]),
            .sub (sub_w[i*BW +: BW]),
            .sel (sel_w[i*BW +: BW])
        );
    end

    sbox_rotator #(.LANES(LN), .BYTE_W(BW)) rot_i (
        .din  (sel_w),
        .amt  (ctl.rot[$clog2(LN)-1:0]),
        .dout (rot_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (wr_valid) begin
            st_d.vld  = 1'b1;
            st_d.data = wr_data;
        end else if (rd_valid) begin
            st_d.vld  = 1'b1;
            st_d.data = rot_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign res_data  = st_q.data;

    // R11
    res_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_valid) |=> res_valid);
    // R11
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid || wr_valid) |=> (!res_valid && $stable(res_data)));
    // R3
    wr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (res_data == $past(wr_data)));
    // R5
    rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !wr_valid && rd_ctrl == 8'h00) |=> (res_data == $past(rd_src)));
endmodule

// File: tb/sbox_unit_tb_top.sv
module sbox_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_src = '0;
    logic [7:0]  rd_ctrl = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  wr_addr = '0;
    logic        res_valid;
    logic [31:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0]  model [4][256];
    logic [31:0] prev_res = '0;

    always #2.5 clk = ~clk;

    sbox_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_src(rd_src), .rd_ctrl(rd_ctrl),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_addr(wr_addr),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_read(input logic [31:0] src, input logic [7:0] c,
                                             input logic [31:0] prev);
        logic [31:0] w, x;
        logic [63:0] d;
        int k;
        w = c[7] ? prev : src;
        for (int i = 0; i < 4; i++) begin
            int b;
            b = c[6] ? (i + 2) % 4 : i;
            x[i*8 +: 8] = c[i] ? model[b][w[i*8 +: 8]] : w[i*8 +: 8];
        end
        k = int'(c[5:4]);
        d = {x, x} << (8 * k);
        return d[63:32];
    endfunction

    task automatic op(input logic rv, input logic [31:0] rs, input logic [7:0] rc,
                      input logic wv, input logic [31:0] wd, input logic [7:0] wa);
        @(negedge clk);
        rd_valid = rv; rd_src = rs; rd_ctrl = rc;
        wr_valid = wv; wr_data = wd; wr_addr = wa;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        op(1'b0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input bit check);
        op(1'b0, '0, '0, 1'b1, d, a);
        for (int b = 0; b < 4; b++) model[b][a] = d[b*8 +: 8];
        prev_res = d;
        if (check) begin
            chk("R3 valid", {31'd0, res_valid}, 32'd1);
            chk("R3 data", res_data, d);
        end
    endtask

    task automatic do_read(input string req, input logic [31:0] s, input logic [7:0] c);
        logic [31:0] e;
        e = ref_read(s, c, prev_res);
        op(1'b1, s, c, 1'b0, '0, '0);
        chk({req, " valid"}, {31'd0, res_valid}, 32'd1);
        chk(req, res_data, e);
        prev_res = e;
    endtask

    task automatic t_reset();
        chk("R1 valid", {31'd0, res_valid}, 32'd0);
        chk("R1 data", res_data, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 valid after release", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_load();
        for (int a = 0; a < 256; a++) begin
            logic [31:0] d;
            for (int b = 0; b < 4; b++) d[b*8 +: 8] = 8'(a * (2*b + 3) + 37*b + 11);
            do_write(8'(a), d, a == 5 || a == 200);
        end
        idle();
        chk("R11 idle after load", {31'd0, res_valid}, 32'd0);
        chk("R11 data held", res_data, prev_res);
    endtask

    task automatic t_full();
        do_read("R8 full word", 32'h0011_22FF, 8'h0F);
        do_read("R8 full word", 32'hDEAD_BEEF, 8'h0F);
        do_read("R4 R2 full word", 32'h0102_0304, 8'h0F);
        idle();
    endtask

    task automatic t_lanes();
        do_read("R4 R5 mask 5", 32'h8899_AABB, 8'h05);
        do_read("R4 R5 mask A", 32'h8899_AABB, 8'h0A);
        do_read("R4 R5 mask 1", 32'h1234_5678, 8'h01);
        do_read("R5 mask 0", 32'hCAFE_F00D, 8'h00);
        idle();
    endtask

    task automatic t_inverse();
        do_read("R6 inverse all", 32'h1020_3040, 8'h4F);
        do_read("R6 inverse mask 3", 32'hA5A5_5A5A, 8'h43);
        idle();
    endtask

    task automatic t_rotate();
        do_read("R7 rot1 raw", 32'h4433_2211, 8'h10);
        do_read("R7 rot2 raw", 32'h4433_2211, 8'h20);
        do_read("R7 rot3 raw", 32'h4433_2211, 8'h30);
        do_read("R7 rot3 sub", 32'h7766_5544, 8'h3F);
        do_read("R7 R6 rot1 inv", 32'h0F1E_2D3C, 8'h59);
        idle();
    endtask

    task automatic t_chain();
        do_read("R9 seed", 32'h1357_9BDF, 8'h0F);
        do_read("R9 chain sub", 32'hFFFF_FFFF, 8'h8F);
        do_read("R9 chain rot", 32'h0000_0000, 8'hA0);
        idle();
    endtask

    task automatic t_collide();
        logic [31:0] nd;
        nd = 32'hA1B2_C3D4;
        op(1'b1, 32'h0707_0707, 8'h0F, 1'b1, nd, 8'h77);
        for (int b = 0; b < 4; b++) model[b][8'h77] = nd[b*8 +: 8];
        prev_res = nd;
        chk("R10 valid", {31'd0, res_valid}, 32'd1);
        chk("R10 write wins", res_data, nd);
        do_read("R10 R2 bank updated", 32'h7777_7777, 8'h0F);
        idle();
        chk("R11 idle", {31'd0, res_valid}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_load();
        t_full();
        t_lanes();
        t_inverse();
        t_rotate();
        t_chain();
        t_collide();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule